// File: doc/BRIEF.md
# Indexed Configuration Window

This block gives a small set of configuration bytes behind two adjacent byte-wide I/O addresses. The lower address works as a pointer: a byte written there selects one of 256 byte-wide configuration entries. The upper address is the data port. A read returns the selected entry, and a write updates it, but only if that entry's write rule allows the value.

Each entry has one of three write rules, fixed at design time. Locked entries ignore every write. Open entries take any byte. Keyed entries take only their single allowed value. A set of entries comes out of reset with fixed defaults. The window responds only while one enable bit of an external control byte is set. While that bit is clear, the window does not claim accesses, reads return all ones and writes change nothing.

The block decodes the two addresses itself. Reads are combinational in the cycle of the read strobe. Writes take effect on the clock edge where the write strobe is high. Only single-byte accesses exist.

Top module: `cfg_index_port`

## Requirements
- R1: After synchronous reset the pointer is 0x00. Entries 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 read 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE. Every other entry reads 0x00.
- R2: An enabled write to the pointer address (BASE, default 0x3F0) stores the written byte as the pointer from the next cycle on.
- R3: An enabled read at either window address (BASE or BASE+1) returns, in the same cycle, the entry that the pointer selects.
- R4: Data-port writes leave the entry unchanged when the pointer is in 0x00–0xDF, 0xE9–0xED, 0xF9–0xFB or 0xFD–0xFF, or is 0xE4, 0xE5, 0xF3, 0xF5 or 0xF7.
- R5: Entry 0xE7 changes only when 0xFE is written to it, and entry 0xE8 changes only when 0xBE is written to it. Any other value leaves the entry as it was.
- R6: Data-port writes to the remaining entries (0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8, 0xFC) store the written byte, and it reads back from the next cycle.
- R7: The window is enabled only while bit EN_BIT (default 1) of `ctrl_byte` is 1. While that bit is 0, reads return 0xFF, and writes change neither the pointer nor any entry.
- R8: Accesses to addresses outside the two-address window return 0xFF and change no state.
- R9: `claim` is high exactly when the window is enabled, the address is BASE or BASE+1, and a read or write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_byte | input | 8 | External control byte; bit EN_BIT enables the window |
| io_addr | input | 16 | I/O address of the access |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| claim | output | 1 | The window decodes the current access |

## Verification
The bench walks every one of the 256 entries. At each entry it writes a pattern byte derived from the index and then reads it back. This separates the locked, open and keyed rules at every range boundary, for example 0xDF/0xE0, 0xED/0xEE and 0xFC/0xFD. Keyed entries get both a wrong value and the accepted value, which shows that the value comparison works and not only the index decode. Pointer and data writes are also tried with the enable bit clear while the other control bits are set, and at addresses just outside the window. Each of these runs is followed by read-back once the window is enabled again, so any change that leaked through shows up.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    localparam int unsigned NUM_ENT = 256;
    localparam int unsigned IDX_W   = $clog2(NUM_ENT);
    localparam int unsigned DAT_W   = 8;

    typedef enum logic [1:0] {
        RULE_LOCKED = 2'd0,
        RULE_OPEN   = 2'd1,
        RULE_KEYED  = 2'd2
    } wr_rule_e;

    typedef struct packed {
        logic sel;      // enabled and address inside the window
        logic is_data;  // upper address of the pair
        logic rd;
        logic wr;
    } port_req_t;

    function automatic wr_rule_e rule_of(int unsigned i);
        if (i <= 32'hDF)                    return RULE_LOCKED;
        if (i == 32'hE7 || i == 32'hE8)     return RULE_KEYED;
        if (i == 32'hE4 || i == 32'hE5)     return RULE_LOCKED;
        if (i >= 32'hE9 && i <= 32'hED)     return RULE_LOCKED;
        if (i == 32'hF3 || i == 32'hF5 || i == 32'hF7) return RULE_LOCKED;
        if (i >= 32'hF9 && i <= 32'hFB)     return RULE_LOCKED;
        if (i >= 32'hFD)                    return RULE_LOCKED;
        return RULE_OPEN;
    endfunction

    function automatic logic [DAT_W-1:0] key_of(int unsigned i);
        case (i)
            32'hE7:  return 8'hFE;
            32'hE8:  return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DAT_W-1:0] default_of(int unsigned i);
        case (i)
            32'hE0:  return 8'h3C;
            32'hE2:  return 8'h03;
            32'hE3:  return 8'hFC;
            32'hE6:  return 8'hDE;
            32'hE7:  return 8'hFE;
            32'hE8:  return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfgwin_pkg::*;
#(
    parameter int unsigned          ADDR_W = 16,
    parameter logic [ADDR_W-1:0]    BASE   = 16'h03F0,
    parameter int unsigned          EN_BIT = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [7:0]        ctrl,
    output port_req_t         req
);
    localparam logic [ADDR_W-2:0] PAIR = BASE[ADDR_W-1:1];

    logic in_pair;
    logic unused_ctrl;

    assign in_pair     = (addr[ADDR_W-1:1] == PAIR);
    assign unused_ctrl = ^(ctrl & ~(8'd1 << EN_BIT)) ^ BASE[0];

    always_comb begin
        req.sel     = in_pair && ctrl[EN_BIT];
        req.is_data = addr[0];
        req.rd      = rd;
        req.wr      = wr;
    end
endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg
    import cfgwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DAT_W-1:0] din,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (load) idx <= din[IDX_W-1:0];
    end
endmodule

// File: rtl/cfg_reg_array.sv
module cfg_reg_array
    import cfgwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [DAT_W-1:0] wdata,
    output logic [DAT_W-1:0] rd_data
);
    logic [DAT_W-1:0] ent [NUM_ENT];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        localparam wr_rule_e       RULE = rule_of(i);
        localparam logic [DAT_W-1:0] RST = default_of(i);
        localparam logic [DAT_W-1:0] KEY = key_of(i);

        if (RULE == RULE_LOCKED) begin : g_const
            assign ent[i] = RST;
        end else begin : g_store
            logic [DAT_W-1:0] q;
            logic             take;

            if (RULE == RULE_KEYED) begin : g_key
                assign take = (wdata == KEY);
            end else begin : g_any
                assign take = 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst)
                    q <= RST;
                else if (wr && idx == IDX_W'(i) && take)
                    q <= wdata;
            end
            assign ent[i] = q;
        end
    end

    assign rd_data = ent[idx];
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfgwin_pkg::*;
#(
    parameter int unsigned       ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h03F0,
    parameter int unsigned       EN_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        ctrl_byte,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              claim
);
    port_req_t        req;
    logic [IDX_W-1:0] idx_q;
    logic [DAT_W-1:0] cur_entry;
    logic             idx_load;
    logic             data_wr;

    cfg_port_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .EN_BIT(EN_BIT)) u_dec (
        .addr (io_addr),
        .rd   (io_rd),
        .wr   (io_wr),
        .ctrl (ctrl_byte),
        .req  (req)
    );

    assign idx_load = req.sel && req.wr && !req.is_data;
    assign data_wr  = req.sel && req.wr &&  req.is_data;

    cfg_index_reg u_idx (
        .clk  (clk),
        .rst  (rst),
        .load (idx_load),
        .din  (io_wdata),
        .idx  (idx_q)
    );

    cfg_reg_array u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr      (data_wr),
        .idx     (idx_q),
        .wdata   (io_wdata),
        .rd_data (cur_entry)
    );

    assign io_rdata = (req.sel && req.rd) ? cur_entry : 8'hFF;
    assign claim    = req.sel && (req.rd || req.wr);
endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk
    import cfgwin_pkg::*;
#(
    parameter int unsigned       ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h03F0,
    parameter int unsigned       EN_BIT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        ctrl_byte,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              claim,
    input logic [IDX_W-1:0]  idx_q,
    input logic [DAT_W-1:0]  cur_entry
);
    logic en, at_idx, at_dat;
    assign en     = ctrl_byte[EN_BIT];
    assign at_idx = (io_addr == BASE);
    assign at_dat = (io_addr == BASE + ADDR_W'(1));

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (rst)
        (en && io_wr && at_idx) |=> (idx_q == $past(io_wdata)));

    // R7
    off_idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && io_wr) |=> $stable(idx_q));

    // R7
    off_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && io_rd) |-> (io_rdata == 8'hFF));

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && io_wr && at_dat && rule_of(int'(idx_q)) == RULE_LOCKED) |=> $stable(cur_entry));

    // R5
    keyed_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (en && io_wr && at_dat && rule_of(int'(idx_q)) == RULE_KEYED
         && io_wdata != key_of(int'(idx_q))) |=> $stable(cur_entry));

    // R6
    open_store_chk: assert property (@(posedge clk) disable iff (rst)
        (en && io_wr && at_dat && rule_of(int'(idx_q)) == RULE_OPEN)
        |=> (cur_entry == $past(io_wdata)));

    // R9
    claim_match_chk: assert property (@(posedge clk) disable iff (rst)
        claim == (en && (at_idx || at_dat) && (io_rd || io_wr)));

    // R8
    outside_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (!at_idx && !at_dat) |-> (io_rdata == 8'hFF && !claim));
endmodule

bind cfg_index_port cfg_index_port_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .EN_BIT(EN_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_byte (ctrl_byte),
    .io_addr   (io_addr),
    .io_rd     (io_rd),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .claim     (claim),
    .idx_q     (idx_q),
    .cur_entry (cur_entry)
);

// File: tb/sim_cfg_index_port.sv
`timescale 1ns/1ps
module sim_cfg_index_port;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  ctrl_byte;
    logic [15:0] io_addr;
    logic        io_rd, io_wr;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic        claim;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    byte unsigned mdl_mem [256];
    byte unsigned mdl_idx;

    always #10 clk = ~clk;

    cfg_index_port u0 (
        .clk(clk), .rst(rst), .ctrl_byte(ctrl_byte), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .claim(claim)
    );

    // 0 locked, 1 open, 2 keyed
    function automatic int kind(int i);
        if (i == 'hE7 || i == 'hE8) return 2;
        case (i)
            'hE0, 'hE1, 'hE2, 'hE3, 'hE6, 'hEE, 'hEF, 'hF0, 'hF1, 'hF2,
            'hF4, 'hF6, 'hF8, 'hFC: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int i);
        case (kind(i))
            0: return "R4";
            1: return "R6";
            default: return "R5";
        endcase
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'h00;
        mdl_mem['hE0] = 8'h3C; mdl_mem['hE2] = 8'h03; mdl_mem['hE3] = 8'hFC;
        mdl_mem['hE6] = 8'hDE; mdl_mem['hE7] = 8'hFE; mdl_mem['hE8] = 8'hBE;
        mdl_idx = 8'h00;
    endtask

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after the falling edge, compare outputs, then
    // advance the model at the rising edge.
    task automatic op(string tag, logic [15:0] a, bit r, bit w, logic [7:0] d);
        bit en, win;
        logic [7:0] exp_rd;
        @(negedge clk);
        io_addr = a; io_rd = r; io_wr = w; io_wdata = d;
        #2;
        en  = ctrl_byte[1];
        win = (a == 16'h03F0) || (a == 16'h03F1);
        exp_rd = (en && win && r) ? mdl_mem[mdl_idx] : 8'hFF;
        check8({tag, " rdata"}, io_rdata, exp_rd);
        check8("R9 claim", {7'd0, claim}, {7'd0, en && win && (r || w)});
        @(posedge clk);
        if (en && win && w) begin
            if (a == 16'h03F0) mdl_idx = d;
            else begin
                case (kind(int'(mdl_idx)))
                    1: mdl_mem[mdl_idx] = d;
                    2: if ((mdl_idx == 8'hE7 && d == 8'hFE) ||
                           (mdl_idx == 8'hE8 && d == 8'hBE)) mdl_mem[mdl_idx] = d;
                    default: ;
                endcase
            end
        end
        #1;
        io_rd = 0; io_wr = 0;
    endtask

    task automatic rd_at(string tag, logic [7:0] i);
        op("R2", 16'h03F0, 0, 1, i);
        op(tag, 16'h03F1, 1, 0, 8'h00);
    endtask

    initial begin
        rst = 1; ctrl_byte = 8'h00; io_addr = 16'h0; io_rd = 0; io_wr = 0; io_wdata = 0;
        mdl_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R7: disabled after reset, reads give all ones
        op("R7", 16'h03F1, 1, 0, 8'h00);
        ctrl_byte = 8'h02;

        // R1: reset pointer is zero; reset defaults
        op("R1", 16'h03F1, 1, 0, 8'h00);
        foreach (mdl_mem[k]) if (k >= 'hE0) rd_at("R1", 8'(k));

        // R2/R3: pointer write then read at both addresses
        op("R2", 16'h03F0, 0, 1, 8'hE6);
        op("R3", 16'h03F0, 1, 0, 8'h00);
        op("R3", 16'h03F1, 1, 0, 8'h00);

        // R4/R5/R6: every entry gets a pattern and is read back
        for (int i = 0; i < 256; i++) begin
            op("R2", 16'h03F0, 0, 1, 8'(i));
            op(tag_of(i), 16'h03F1, 0, 1, 8'(i) ^ 8'h5A);
            op(tag_of(i), 16'h03F1, 1, 0, 8'h00);
        end

        // R5: wrong value rejected, key accepted
        op("R2", 16'h03F0, 0, 1, 8'hE7);
        op("R5", 16'h03F1, 0, 1, 8'h00);
        op("R5", 16'h03F1, 1, 0, 8'h00);
        op("R5", 16'h03F1, 0, 1, 8'hFE);
        op("R5", 16'h03F1, 1, 0, 8'h00);
        op("R2", 16'h03F0, 0, 1, 8'hE8);
        op("R5", 16'h03F1, 0, 1, 8'hBF);
        op("R5", 16'h03F1, 1, 0, 8'h00);
        op("R5", 16'h03F1, 0, 1, 8'hBE);
        op("R5", 16'h03F1, 1, 0, 8'h00);

        // R6: open entry takes several values
        op("R2", 16'h03F0, 0, 1, 8'hF2);
        op("R6", 16'h03F1, 0, 1, 8'hFF);
        op("R6", 16'h03F1, 1, 0, 8'h00);
        op("R6", 16'h03F1, 0, 1, 8'h00);
        op("R6", 16'h03F1, 1, 0, 8'h00);

        // R7: disabled with other control bits set; writes must not land
        op("R2", 16'h03F0, 0, 1, 8'hE0);
        ctrl_byte = 8'hFD;
        op("R7", 16'h03F0, 0, 1, 8'hE1);
        op("R7", 16'h03F1, 0, 1, 8'h77);
        op("R7", 16'h03F1, 1, 0, 8'h00);
        ctrl_byte = 8'h02;
        op("R7", 16'h03F1, 1, 0, 8'h00);

        // R8: neighbours of the window
        op("R8", 16'h03F2, 0, 1, 8'h11);
        op("R8", 16'h03EF, 0, 1, 8'h22);
        op("R8", 16'h02F1, 0, 1, 8'h33);
        op("R8", 16'h03F2, 1, 0, 8'h00);
        op("R8", 16'h03F1, 1, 0, 8'h00);

        // R1: reset again restores defaults
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        mdl_reset();
        op("R1", 16'h03F1, 1, 0, 8'h00);
        rd_at("R1", 8'hE0);
        rd_at("R1", 8'hF2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule